// File: doc/BRIEF.md
# Configuration Port Bank-Control Decoder

This block sits behind two configuration I/O ports and turns accesses on them into a single byte register that controls memory banking. The address port holds a 32-bit pointer. Its top bit opens the data window. Bits 23:2 select a double-word of configuration space. The data window is four byte-wide ports, and the port offset supplies the two low address bits. A 32-bit access to the window touches all four bytes, with the lowest offset in the least significant byte.

Only one configuration byte is implemented. A write to that byte stores it for read-back. The write also rebuilds the upper six bits of a 16-bit memory-window control word that the block hands to the memory-mapping logic around it. The lower ten bits of that word come only from a separate preset input, and register writes never change them.

Each access is a one-cycle strobe, and every strobe is accepted in the cycle it is presented. The block has no back-pressure and no handshake. Read data is combinational from the port selection and the current state.

Top module: `cfg_bank_decoder`

## Requirements
- R1: A 32-bit write (acc_word=1) with acc_port[2]=0 loads the address latch on the next clock edge. A 32-bit read of that port returns the latch value.
- R2: While latch bit 31 is 0, data-window reads (acc_port[2]=1) return all ones, and data-window writes change neither the stored byte nor ctrl_word.
- R3: The configuration byte address is latch bits 23:2 followed by acc_port[1:0]. Latch bits 30:24 and 1:0 take no part in decoding. A byte read returns the byte in bits 7:0 with bits 31:8 all ones.
- R4: A 32-bit data-window access covers byte offsets 0..3, with offset k in bits 8k+7:8k. With the latch pointing at 0x64, the register occupies bits 31:24. acc_port[1:0] is ignored for 32-bit accesses.
- R5: Only configuration byte address 0x67 is implemented. Every other byte reads 0xFF, and writes to other bytes have no effect.
- R6: A byte written to 0x67 reads back unchanged.
- R7: A register write leaves ctrl_word[9:0] unchanged.
- R8: A register write sets ctrl_word[10] from data bit 4 and ctrl_word[11] from data bit 5. It sets ctrl_word[15:12] to 0xF if data bit 7 is 1 and to 0x0 if it is 0. Data bits 3:0 and 6 do not affect ctrl_word.
- R9: preset_load=1 loads preset_val into ctrl_word[9:0] on the next edge. This works in the same cycle as a register write.
- R10: Reset (rst_n=0) clears the address latch, the stored byte and ctrl_word.
- R11: Byte accesses (acc_word=0) to the address port are ignored, and byte reads of that port return all ones.
- R12: State changes on the first clock edge at which acc_valid and acc_write are high. Read data reflects the new state immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, always accepted |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| acc_port | input | 3 | Bit 2: 0 = address port, 1 = data window; bits 1:0 give the byte offset |
| acc_wdata | input | 32 | Write data; byte writes use bits 7:0 |
| rd_data | output | 32 | Combinational read data for the selected port |
| preset_load | input | 1 | Load preset_val into the low control bits |
| preset_val | input | 10 | Value for ctrl_word[9:0] |
| ctrl_word | output | 16 | Memory-window control word |

## Verification
The bench targets decoding against the masked latch. It uses latch values with junk in bits 30:24 and 1:0, which a design that decoded the full latch would miss. It also moves the latch one double-word away, where a design comparing too few bits would alias the register. It sends data patterns that set only the ignored bits and all-ones patterns, which catch a wrong bit-expansion or a write that corrupts bits 9:0. It checks byte reads on off-target lanes and 32-bit lane order, which expose swapped lanes. It closes the window with bit 31 clear, which a design that ignored the enable would fail.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned LANES   = DATA_W / BYTE_W;
  localparam int unsigned CTRL_W  = 16;
  localparam int unsigned KEEP_W  = 10;
  localparam int unsigned UPPER_W = CTRL_W - KEEP_W;

  // Expand a register byte into the upper control bits:
  // {4 copies of bit 7, bit 5, bit 4}
  function automatic logic [UPPER_W-1:0] expand_upper(input logic [BYTE_W-1:0] d);
    return {{(UPPER_W-2){d[7]}}, d[5], d[4]};
  endfunction
endpackage

// File: rtl/cfgb_addr_latch.sv
module cfgb_addr_latch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= din;
  end
endmodule

// File: rtl/cfgb_bank_reg.sv
module cfgb_bank_reg
  import cfgb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wd,
  input  logic              preset_load,
  input  logic [KEEP_W-1:0] preset_val,
  output logic [BYTE_W-1:0] reg_q,
  output logic [CTRL_W-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr) begin
        reg_q                 <= wd;
        ctrl_q[CTRL_W-1:KEEP_W] <= expand_upper(wd);
      end
      if (preset_load) ctrl_q[KEEP_W-1:0] <= preset_val;
    end
  end
endmodule

// File: rtl/cfgb_read_mux.sv
module cfgb_read_mux
  import cfgb_pkg::*;
(
  input  logic              sel_data,
  input  logic              word,
  input  logic [1:0]        lane,
  input  logic [DATA_W-1:0] addr_q,
  input  logic [DATA_W-1:0] window,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    if (!sel_data)
      rd_data = word ? addr_q : '1;
    else if (word)
      rd_data = window;
    else
      rd_data = {{(DATA_W-BYTE_W){1'b1}}, window[BYTE_W*lane +: BYTE_W]};
  end
endmodule

// File: rtl/cfg_bank_decoder.sv
module cfg_bank_decoder
  import cfgb_pkg::*;
#(
  parameter logic [23:0] CFG_ADDR = 24'h000067,
  parameter int unsigned EN_BIT   = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_word,
  input  logic [2:0]        acc_port,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              preset_load,
  input  logic [KEEP_W-1:0] preset_val,
  output logic [CTRL_W-1:0] ctrl_word
);
  localparam logic [21:0] TGT_DW   = CFG_ADDR[23:2];
  localparam int unsigned TGT_LANE = int'(CFG_ADDR[1:0]);

  logic [DATA_W-1:0] addr_q;
  logic [BYTE_W-1:0] reg_q;
  logic              win_open;
  logic              addr_ld;
  logic              data_wr;
  logic [LANES-1:0]  wr_lane;
  logic [DATA_W-1:0] window;
  logic [DATA_W-1:0] lane_wd;

  assign addr_ld  = acc_valid && acc_write && acc_word && !acc_port[2];
  assign data_wr  = acc_valid && acc_write && acc_port[2];
  assign win_open = addr_q[EN_BIT] && (addr_q[23:2] == TGT_DW);

  cfgb_addr_latch #(.W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .ld(addr_ld), .din(acc_wdata), .q(addr_q)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic lane_on;
    logic lane_hit;
    assign lane_on  = acc_word || (acc_port[1:0] == 2'(k));
    assign lane_hit = win_open && (k == TGT_LANE);
    assign window[BYTE_W*k +: BYTE_W]  = lane_hit ? reg_q : 8'hFF;
    assign lane_wd[BYTE_W*k +: BYTE_W] = acc_word ? acc_wdata[BYTE_W*k +: BYTE_W]
                                                  : acc_wdata[BYTE_W-1:0];
    assign wr_lane[k] = data_wr && lane_on && lane_hit;
  end

  cfgb_bank_reg u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr(|wr_lane), .wd(lane_wd[BYTE_W*TGT_LANE +: BYTE_W]),
    .preset_load(preset_load), .preset_val(preset_val),
    .reg_q(reg_q), .ctrl_q(ctrl_word)
  );

  cfgb_read_mux u_rmux (
    .sel_data(acc_port[2]), .word(acc_word), .lane(acc_port[1:0]),
    .addr_q(addr_q), .window(window), .rd_data(rd_data)
  );
endmodule

// File: rtl/cfgb_checker.sv
module cfgb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic        acc_word,
  input logic [2:0]  acc_port,
  input logic [31:0] acc_wdata,
  input logic [31:0] rd_data,
  input logic        preset_load,
  input logic [9:0]  preset_val,
  input logic [15:0] ctrl_word,
  input logic [31:0] addr_q
);
  a_r1_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_word && !acc_port[2]) |=> addr_q == $past(acc_wdata));

  a_r2_closed_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_port[2] && !addr_q[31]) |-> rd_data == 32'hFFFF_FFFF);

  a_r2_closed_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_port[2] && !addr_q[31] && !preset_load) |=> $stable(ctrl_word));

  a_r7_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !preset_load) |=> ctrl_word[9:0] == $past(ctrl_word[9:0]));

  a_r8_nibble_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[15:12] == 4'h0) || (ctrl_word[15:12] == 4'hF));

  a_r9_preset: assert property (@(posedge clk) disable iff (!rst_n)
    preset_load |=> ctrl_word[9:0] == $past(preset_val));

  a_r11_addr_byte_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_port[2] && !acc_word) |-> rd_data == 32'hFFFF_FFFF);
endmodule

bind cfg_bank_decoder cfgb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_word(acc_word), .acc_port(acc_port), .acc_wdata(acc_wdata),
  .rd_data(rd_data), .preset_load(preset_load), .preset_val(preset_val),
  .ctrl_word(ctrl_word), .addr_q(addr_q)
);

// File: tb/sim_cfg_bank_decoder.sv
module sim_cfg_bank_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write, acc_word;
  logic [2:0]  acc_port;
  logic [31:0] acc_wdata;
  logic [31:0] rd_data;
  logic        preset_load;
  logic [9:0]  preset_val;
  logic [15:0] ctrl_word;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [31:0] m_addr;
  logic [7:0]  m_reg;
  logic [15:0] m_ctrl;

  always #2 clk = ~clk;

  cfg_bank_decoder u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_word(acc_word), .acc_port(acc_port), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .preset_load(preset_load), .preset_val(preset_val),
    .ctrl_word(ctrl_word)
  );

  function automatic logic [7:0] m_byte(int off);
    logic [31:0] a;
    a = (m_addr & 32'h00FF_FFFC) + 32'(off);
    if (!m_addr[31]) return 8'hFF;
    if (a == 32'h67) return m_reg;
    return 8'hFF;
  endfunction

  function automatic logic [31:0] m_read(logic word, logic [2:0] port);
    logic [31:0] r;
    if (!port[2]) return word ? m_addr : 32'hFFFF_FFFF;
    if (!word) return {24'hFFFFFF, m_byte(int'(port[1:0]))};
    r = '0;
    for (int o = 0; o < 4; o++) r[8*o +: 8] = m_byte(o);
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic v, logic w, logic wd, logic [2:0] port,
                      logic [31:0] data, logic pl = 1'b0, logic [9:0] pv = '0);
    logic [7:0] b;
    logic [31:0] a;
    acc_valid = v; acc_write = w; acc_word = wd; acc_port = port;
    acc_wdata = data; preset_load = pl; preset_val = pv;
    #1;
    check({tag, " rd_data"}, rd_data, m_read(wd, port));
    check({tag, " ctrl_word"}, {16'h0, ctrl_word}, {16'h0, m_ctrl});
    @(posedge clk);
    if (v && w) begin
      if (!port[2]) begin
        if (wd) m_addr = data;
      end else if (m_addr[31]) begin
        for (int o = 0; o < 4; o++) begin
          a = (m_addr & 32'h00FF_FFFC) + 32'(o);
          if ((wd || port[1:0] == 2'(o)) && a == 32'h67) begin
            b = wd ? data[8*o +: 8] : data[7:0];
            m_reg = b;
            m_ctrl[10] = b[4];
            m_ctrl[11] = b[5];
            m_ctrl[15:12] = b[7] ? 4'hF : 4'h0;
          end
        end
      end
    end
    if (pl) m_ctrl[9:0] = pv;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    acc_valid = 0; acc_write = 0; acc_word = 0; acc_port = 0;
    acc_wdata = 0; preset_load = 0; preset_val = 0;
    repeat (2) @(posedge clk);
    m_addr = 0; m_reg = 0; m_ctrl = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    m_addr = 32'hDEAD_BEEF; m_reg = 8'h5A; m_ctrl = 16'h1234;
    do_reset();
    // R10 reset state
    step("R10 reset latch", 1, 0, 1, 3'b000, 0);
    check("R10 reset ctrl", {16'h0, ctrl_word}, 32'h0);
    // R11 byte access to address port
    step("R11 byte write addr port", 1, 1, 0, 3'b000, 32'h8000_0064);
    step("R11 byte read addr port", 1, 0, 0, 3'b001, 0);
    step("R11 latch untouched", 1, 0, 1, 3'b000, 0);
    // R2 closed window write
    step("R2 closed write", 1, 1, 0, 3'b111, 32'hFF);
    // R1 latch load and read-back
    step("R1 load latch", 1, 1, 1, 3'b000, 32'h8000_0064);
    step("R1 latch readback", 1, 0, 1, 3'b000, 0);
    step("R2 reg still clear", 1, 0, 0, 3'b111, 0);
    // R12/R8 register write, visible right after the edge
    step("R12 write B5", 1, 1, 0, 3'b111, 32'hB5);
    step("R6 readback B5", 1, 0, 0, 3'b111, 0);
    step("R3 other lane", 1, 0, 0, 3'b100, 0);
    step("R4 word read", 1, 0, 1, 3'b110, 0);
    // R8 ignored bits / single bits
    step("R8 write 4F", 1, 1, 0, 3'b111, 32'h4F);
    step("R8 write 10", 1, 1, 0, 3'b111, 32'h10);
    step("R8 write 20", 1, 1, 0, 3'b111, 32'h20);
    step("R8 write 80", 1, 1, 0, 3'b111, 32'h80);
    // R9 preset, then R7 preservation
    step("R9 preset", 0, 0, 0, 3'b000, 0, 1, 10'h2AB);
    step("R7 write FF", 1, 1, 0, 3'b111, 32'hFF);
    step("R7 write 00 with preset", 1, 1, 0, 3'b111, 32'h00, 1, 10'h155);
    step("R7 after", 1, 0, 0, 3'b111, 0);
    // R4 word write: register takes bits 31:24
    step("R4 word write", 1, 1, 1, 3'b101, 32'h9A11_2233);
    step("R4 word readback", 1, 0, 1, 3'b100, 0);
    // R3 masked latch bits
    step("R3 junk latch", 1, 1, 1, 3'b000, 32'hFF00_0067);
    step("R3 junk latch read", 1, 0, 0, 3'b111, 0);
    step("R3 junk latch write", 1, 1, 0, 3'b111, 32'h3C);
    // R5 other addresses
    step("R5 latch 68", 1, 1, 1, 3'b000, 32'h8000_0068);
    step("R5 write elsewhere", 1, 1, 1, 3'b100, 32'h0000_0000);
    step("R5 byte write elsewhere", 1, 1, 0, 3'b111, 32'h00);
    step("R5 read elsewhere", 1, 0, 1, 3'b100, 0);
    step("R5 latch 60", 1, 1, 1, 3'b000, 32'h8000_0060);
    step("R5 read 60", 1, 0, 1, 3'b100, 0);
    step("R5 back to 64", 1, 1, 1, 3'b000, 32'h8000_0064);
    step("R5 reg kept", 1, 0, 0, 3'b111, 0);
    // R2 disabled window
    step("R2 disable", 1, 1, 1, 3'b000, 32'h0000_0064);
    step("R2 closed word read", 1, 0, 1, 3'b100, 0);
    step("R2 closed write FF", 1, 1, 1, 3'b100, 32'hFFFF_FFFF);
    step("R2 reenable", 1, 1, 1, 3'b000, 32'h8000_0064);
    step("R2 reg unchanged", 1, 0, 0, 3'b111, 0);
    // R12 no strobe, no change
    step("R12 no valid", 0, 1, 0, 3'b111, 32'hFF);
    step("R12 after idle", 1, 0, 0, 3'b111, 0);
    // R10 reset mid-run
    do_reset();
    step("R10 reset again", 1, 0, 1, 3'b000, 0);
    step("R10 reg cleared", 1, 1, 1, 3'b000, 32'h8000_0064);
    step("R10 reg read", 1, 0, 0, 3'b111, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule